// File: doc/BRIEF.md
# Sum-of-Products to Reversible Gate List Generator

The block turns an exclusive-sum-of-products description of a multi-output Boolean function into an ordered list of reversible gates. The circuit it describes has N_IN input lines followed by N_OUT result lines. The result lines begin at constant zero. Each product term (a "cube") becomes one multi-control inversion gate for every result line the cube feeds. The controls of such a gate are the input lines that take part in the cube. A negated literal is served by placing a control-free inverter on its input line before the gate.

A controller starts the block with a one-cycle `start` pulse. The block then reads cubes in ascending address order from an external memory with combinational read, up to `cube_count` of them. It streams one gate record per cycle on the gate outputs. The block tracks which input lines are currently inverted. It inverts a line only when a cube needs that line in the other polarity, and leaves lines alone that a cube does not use. After the last cube it puts every inverted input line back to its true value. A one-cycle `done` pulse closes the run. At that point `gate_count` holds the number of records sent and `overflow` shows whether any records were dropped at the capacity limit.

Top module: `esop_toffoli_gen`

## Requirements
- R1: Line numbering: lines 0 to N_IN-1 are inputs and lines N_IN to N_IN+N_OUT-1 are results. A gate record is `gate_ctrl` (bit i set means input line i is a control) and `gate_target` (the line index). An inverter on an input line carries `gate_ctrl` = 0. Controls never sit on result lines.
- R2: Cube word layout: bits [N_IN-1:0] hold polarity (1 = true literal, 0 = negated literal). Bits [2*N_IN-1:N_IN] hold presence (1 = the literal is used, 0 = absent, polarity ignored). Bits [2*N_IN+N_OUT-1:2*N_IN] hold the result mask (bit j selects result line N_IN+j).
- R3: For each cube in address order, the block first emits inverters in ascending line order. It does this for every present literal whose line inversion state differs from what the literal needs (inverted for a negated literal, true for a true literal). It then emits one gate per set mask bit in ascending result order, with `gate_ctrl` equal to the presence field.
- R4: A cube whose result mask is all zero emits no gate and leaves the inversion state unchanged.
- R5: A cube with no literal present emits gates with `gate_ctrl` = 0 onto each selected result line.
- R6: After the last cube, an inverter is emitted in ascending order on each input line still inverted. When `done` is high, no input line is inverted.
- R7: At most MAX_GATES records are emitted per run. Records past that limit are dropped, `overflow` is set, and `gate_count` stays at MAX_GATES. Each emitted record raises `gate_count` by one in the same cycle that `gate_valid` is high.
- R8: `start` is accepted only while `busy` is low, and it clears `gate_count` and `overflow`. A `start` pulse during a run is ignored. `done` is a one-cycle pulse seen while `busy` is low. `gate_valid` is never high while `busy` is low.
- R9: After reset `busy`, `done`, `gate_valid`, `gate_count` and `overflow` are all zero.
- R10: A run with `cube_count` = 0 ends with `done` and no gates. Reading stops after `cube_count` cubes or after MAX_CUBES cubes, whichever comes first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| cube_count | input | $clog2(MAX_CUBES+1) | Number of cubes to read; held stable during a run |
| cube_addr | output | $clog2(MAX_CUBES) | Address of the cube being read |
| cube_data | input | 2*N_IN+N_OUT | Cube word at `cube_addr`, same cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| gate_valid | output | 1 | A gate record is present this cycle |
| gate_ctrl | output | N_IN | Control line set of the record |
| gate_target | output | $clog2(N_IN+N_OUT) | Target line of the record |
| gate_count | output | $clog2(MAX_GATES+1) | Records emitted in the current or last run |
| overflow | output | 1 | Records were dropped at the capacity limit |

## Verification
The assertions assume three things. First, the cube memory answers in the same cycle. Second, `cube_count` does not change while `busy` is high. Third, `start` is a single-cycle pulse. On those terms, the claims that records target only legal lines and that the count saturates hold for any cube contents. The bench never changes the memory or `cube_count` during a run. It drives `start` for exactly one cycle, and keeps `cube_count` within MAX_CUBES. Its random cubes draw presence, polarity and mask bits freely, with a bias toward empty masks. Its directed cases force shared negated literals, empty cubes, control-free cubes, capacity overflow and a repeated start.

// File: rtl/esop_gen_pkg.sv
`timescale 1ns/1ps
package esop_gen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_FLIP  = 3'd2,
        ST_GATE  = 3'd3,
        ST_REST  = 3'd4,
        ST_FIN   = 3'd5
    } gen_state_e;

endpackage

// File: rtl/esop_low_pick.sv
`timescale 1ns/1ps
// Lowest-set-bit picker: index and one-hot of the least significant set bit.
module esop_low_pick #(
    parameter int W  = 4,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  onehot
);

    always_comb begin
        idx    = '0;
        onehot = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (vec[k]) begin
                idx       = IW'(k);
                onehot    = '0;
                onehot[k] = 1'b1;
            end
        end
        any = |vec;
    end

endmodule

// File: rtl/esop_cube_decode.sv
`timescale 1ns/1ps
// Splits a cube word into presence mask, required inversion mask and result mask.
module esop_cube_decode #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 3
) (
    input  logic [2*N_IN+N_OUT-1:0] cube,
    output logic [N_IN-1:0]         present,
    output logic [N_IN-1:0]         want_inv,
    output logic [N_OUT-1:0]        res_mask,
    output logic                    has_res
);

    logic [N_IN-1:0] polarity;

    always_comb begin
        polarity = cube[N_IN-1:0];
        present  = cube[2*N_IN-1:N_IN];
        res_mask = cube[2*N_IN+N_OUT-1:2*N_IN];
        want_inv = present & ~polarity;
        has_res  = |res_mask;
    end

endmodule

// File: rtl/esop_toffoli_gen.sv
`timescale 1ns/1ps
module esop_toffoli_gen
    import esop_gen_pkg::*;
#(
    parameter int N_IN      = 4,
    parameter int N_OUT     = 3,
    parameter int MAX_CUBES = 16,
    parameter int MAX_GATES = 64
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic [$clog2(MAX_CUBES+1)-1:0]      cube_count,
    output logic [$clog2(MAX_CUBES)-1:0]        cube_addr,
    input  logic [2*N_IN+N_OUT-1:0]             cube_data,
    output logic                                busy,
    output logic                                done,
    output logic                                gate_valid,
    output logic [N_IN-1:0]                     gate_ctrl,
    output logic [$clog2(N_IN+N_OUT)-1:0]       gate_target,
    output logic [$clog2(MAX_GATES+1)-1:0]      gate_count,
    output logic                                overflow
);

    localparam int CNT_W  = $clog2(MAX_CUBES + 1);
    localparam int ADDR_W = $clog2(MAX_CUBES);
    localparam int LINE_W = $clog2(N_IN + N_OUT);
    localparam int GCNT_W = $clog2(MAX_GATES + 1);
    localparam int IIW    = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int OIW    = (N_OUT > 1) ? $clog2(N_OUT) : 1;

    typedef struct packed {
        gen_state_e         st;
        logic [CNT_W-1:0]   idx;
        logic [N_IN-1:0]    present;
        logic [N_IN-1:0]    want_inv;
        logic [N_OUT-1:0]   pend;
        logic [N_IN-1:0]    inv;
        logic               gv;
        logic [N_IN-1:0]    gctrl;
        logic [LINE_W-1:0]  gtgt;
        logic [GCNT_W-1:0]  gcnt;
        logic               ovf;
        logic               done;
    } gen_regs_t;

    gen_regs_t r_q, r_d;

    // Cube decode of the word currently addressed
    logic [N_IN-1:0]  dec_present;
    logic [N_IN-1:0]  dec_want_inv;
    logic [N_OUT-1:0] dec_mask;
    logic             dec_has_res;

    esop_cube_decode #(
        .N_IN  (N_IN),
        .N_OUT (N_OUT)
    ) u_decode (
        .cube     (cube_data),
        .present  (dec_present),
        .want_inv (dec_want_inv),
        .res_mask (dec_mask),
        .has_res  (dec_has_res)
    );

    // Lines whose inversion state disagrees with the latched cube
    logic [N_IN-1:0] flip_vec;
    logic            flip_any;
    logic [IIW-1:0]  flip_idx;
    logic [N_IN-1:0] flip_oh;

    assign flip_vec = r_q.present & (r_q.inv ^ r_q.want_inv);

    esop_low_pick #(
        .W  (N_IN),
        .IW (IIW)
    ) u_pick_flip (
        .vec    (flip_vec),
        .any    (flip_any),
        .idx    (flip_idx),
        .onehot (flip_oh)
    );

    // Lines still inverted at the end of the list
    logic            rest_any;
    logic [IIW-1:0]  rest_idx;
    logic [N_IN-1:0] rest_oh;

    esop_low_pick #(
        .W  (N_IN),
        .IW (IIW)
    ) u_pick_rest (
        .vec    (r_q.inv),
        .any    (rest_any),
        .idx    (rest_idx),
        .onehot (rest_oh)
    );

    // Result lines still owed a gate for the latched cube
    logic             pend_any;
    logic [OIW-1:0]   pend_idx;
    logic [N_OUT-1:0] pend_oh;

    esop_low_pick #(
        .W  (N_OUT),
        .IW (OIW)
    ) u_pick_pend (
        .vec    (r_q.pend),
        .any    (pend_any),
        .idx    (pend_idx),
        .onehot (pend_oh)
    );

    // Gate request produced by the state logic this cycle
    logic              emit_en;
    logic [N_IN-1:0]   emit_ctrl;
    logic [LINE_W-1:0] emit_tgt;
    logic              list_end;

    always_comb begin
        r_d       = r_q;
        r_d.gv    = 1'b0;
        r_d.done  = 1'b0;
        emit_en   = 1'b0;
        emit_ctrl = '0;
        emit_tgt  = '0;
        list_end  = (r_q.idx >= cube_count) || (r_q.idx == CNT_W'(MAX_CUBES));

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_FETCH;
                    r_d.idx  = '0;
                    r_d.gcnt = '0;
                    r_d.ovf  = 1'b0;
                    r_d.inv  = '0;
                end
            end

            ST_FETCH: begin
                if (list_end) begin
                    r_d.st = ST_REST;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                    if (dec_has_res) begin
                        r_d.present  = dec_present;
                        r_d.want_inv = dec_want_inv;
                        r_d.pend     = dec_mask;
                        r_d.st       = ST_FLIP;
                    end
                end
            end

            ST_FLIP: begin
                if (flip_any) begin
                    emit_en   = 1'b1;
                    emit_ctrl = '0;
                    emit_tgt  = LINE_W'(flip_idx);
                    r_d.inv   = r_q.inv ^ flip_oh;
                end else begin
                    r_d.st = ST_GATE;
                end
            end

            ST_GATE: begin
                if (pend_any) begin
                    emit_en   = 1'b1;
                    emit_ctrl = r_q.present;
                    emit_tgt  = LINE_W'(N_IN) + LINE_W'(pend_idx);
                    r_d.pend  = r_q.pend & ~pend_oh;
                    if ((r_q.pend & ~pend_oh) == '0) begin
                        r_d.st = ST_FETCH;
                    end
                end else begin
                    r_d.st = ST_FETCH;
                end
            end

            ST_REST: begin
                if (rest_any) begin
                    emit_en   = 1'b1;
                    emit_ctrl = '0;
                    emit_tgt  = LINE_W'(rest_idx);
                    r_d.inv   = r_q.inv ^ rest_oh;
                end else begin
                    r_d.st = ST_FIN;
                end
            end

            ST_FIN: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end

            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        // Capacity guard: drop records beyond the limit and flag it
        if (emit_en) begin
            if (r_q.gcnt == GCNT_W'(MAX_GATES)) begin
                r_d.ovf = 1'b1;
            end else begin
                r_d.gv    = 1'b1;
                r_d.gctrl = emit_ctrl;
                r_d.gtgt  = emit_tgt;
                r_d.gcnt  = r_q.gcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Inversion state brought out for the bound checker
    logic [N_IN-1:0] line_inv_q;
    assign line_inv_q = r_q.inv;

    assign cube_addr   = r_q.idx[ADDR_W-1:0];
    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign gate_valid  = r_q.gv;
    assign gate_ctrl   = r_q.gctrl;
    assign gate_target = r_q.gtgt;
    assign gate_count  = r_q.gcnt;
    assign overflow    = r_q.ovf;

endmodule

// File: rtl/esop_gen_checker.sv
`timescale 1ns/1ps
module esop_gen_checker #(
    parameter int N_IN      = 4,
    parameter int N_OUT     = 3,
    parameter int MAX_GATES = 64
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           busy,
    input logic                           done,
    input logic                           gate_valid,
    input logic [N_IN-1:0]                gate_ctrl,
    input logic [$clog2(N_IN+N_OUT)-1:0]  gate_target,
    input logic [$clog2(MAX_GATES+1)-1:0] gate_count,
    input logic                           overflow,
    input logic [N_IN-1:0]                line_inv_q
);

    localparam int GCNT_W = $clog2(MAX_GATES + 1);

    // R1: records on input lines are plain inverters
    p_input_target_no_ctrl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_valid && (int'(gate_target) < N_IN)) |-> (gate_ctrl == '0));

    // R1: target always names an existing line
    p_target_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gate_valid |-> (int'(gate_target) < N_IN + N_OUT));

    // R6: every input line is back to true polarity at the end of a run
    p_lines_restored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (line_inv_q == '0));

    // R7: count never exceeds capacity
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(gate_count) <= MAX_GATES);

    // R7: an overflow means the count sits at capacity
    p_ovf_saturated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (int'(gate_count) == MAX_GATES));

    // R7: each record advances the count by exactly one
    p_count_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_valid |-> (gate_count == GCNT_W'($past(gate_count) + 1'b1)));

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: no record while idle, and done only while idle
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !gate_valid);

    p_done_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind esop_toffoli_gen esop_gen_checker #(
    .N_IN      (N_IN),
    .N_OUT     (N_OUT),
    .MAX_GATES (MAX_GATES)
) u_esop_gen_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .gate_valid  (gate_valid),
    .gate_ctrl   (gate_ctrl),
    .gate_target (gate_target),
    .gate_count  (gate_count),
    .overflow    (overflow),
    .line_inv_q  (line_inv_q)
);

// File: tb/esop_toffoli_gen_bench.sv
`timescale 1ns/1ps
module esop_toffoli_gen_bench;

    localparam int N_IN      = 4;
    localparam int N_OUT     = 3;
    localparam int MAX_CUBES = 16;
    localparam int MAX_GATES = 64;
    localparam int CW        = 2 * N_IN + N_OUT;
    localparam int CNT_W     = $clog2(MAX_CUBES + 1);
    localparam int ADDR_W    = $clog2(MAX_CUBES);
    localparam int LINE_W    = $clog2(N_IN + N_OUT);
    localparam int GCNT_W    = $clog2(MAX_GATES + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  cube_count = '0;
    logic [ADDR_W-1:0] cube_addr;
    logic [CW-1:0]     cube_data;
    logic              busy, done, gate_valid, overflow;
    logic [N_IN-1:0]   gate_ctrl;
    logic [LINE_W-1:0] gate_target;
    logic [GCNT_W-1:0] gate_count;

    logic [CW-1:0] mem [MAX_CUBES];
    assign cube_data = mem[cube_addr];

    always #10 clk = ~clk;

    esop_toffoli_gen #(
        .N_IN(N_IN), .N_OUT(N_OUT), .MAX_CUBES(MAX_CUBES), .MAX_GATES(MAX_GATES)
    ) u_esop_toffoli_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .cube_count(cube_count),
        .cube_addr(cube_addr), .cube_data(cube_data), .busy(busy), .done(done),
        .gate_valid(gate_valid), .gate_ctrl(gate_ctrl), .gate_target(gate_target),
        .gate_count(gate_count), .overflow(overflow)
    );

    int total = 0;
    int bad   = 0;
    int exp_g [256];
    int exp_n;
    int got_g [256];
    int got_n;
    int done_seen;
    bit collecting = 1'b0;

    function automatic int enc(int ctrl, int tgt);
        return ctrl * 256 + tgt;
    endfunction

    function automatic logic [CW-1:0] mk(int mask, int pres, int pol);
        return {N_OUT'(mask), N_IN'(pres), N_IN'(pol)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push_exp(input int v);
        if (exp_n < 256) exp_g[exp_n] = v;
        exp_n++;
    endtask

    // Reference gate list computed from the requirements (R2..R6, R10)
    task automatic build_expected(input int cnt);
        bit [N_IN-1:0] inv;
        inv   = '0;
        exp_n = 0;
        for (int c = 0; c < cnt && c < MAX_CUBES; c++) begin
            logic [CW-1:0] w;
            logic [N_IN-1:0] pol, pres;
            logic [N_OUT-1:0] msk;
            w    = mem[c];
            pol  = w[N_IN-1:0];
            pres = w[2*N_IN-1:N_IN];
            msk  = w[CW-1:2*N_IN];
            if (msk != 0) begin
                for (int i = 0; i < N_IN; i++) begin
                    if (pres[i] && (inv[i] != !pol[i])) begin
                        push_exp(enc(0, i));
                        inv[i] = !pol[i];
                    end
                end
                for (int j = 0; j < N_OUT; j++)
                    if (msk[j]) push_exp(enc(int'(pres), N_IN + j));
            end
        end
        for (int i = 0; i < N_IN; i++)
            if (inv[i]) push_exp(enc(0, i));
    endtask

    always @(negedge clk) begin
        if (collecting) begin
            if (gate_valid) begin
                if (got_n < 256) got_g[got_n] = enc(int'(gate_ctrl), int'(gate_target));
                got_n++;
            end
            if (done) done_seen++;
        end
    end

    task automatic run(input int cnt, input bit restart_mid, input string tag);
        int lim, mism, first_a, first_e, wd;
        bit ok;
        build_expected(cnt);
        lim        = (exp_n > MAX_GATES) ? MAX_GATES : exp_n;
        got_n      = 0;
        done_seen  = 0;
        @(negedge clk);
        cube_count = CNT_W'(cnt);
        collecting = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart_mid) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wd = 0;
        ok = 1'b0;
        while (wd < 5000) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
            wd++;
        end
        chk(ok, {tag, " R8 watchdog/done"}, int'(ok), 1);
        repeat (4) @(negedge clk);
        collecting = 1'b0;
        chk(done_seen == 1, {tag, " R8 done pulses"}, done_seen, 1);
        chk(busy == 1'b0, {tag, " R8 idle after done"}, int'(busy), 0);
        chk(got_n == lim, {tag, " R3 record count"}, got_n, lim);
        chk(int'(gate_count) == lim, {tag, " R7 gate_count"}, int'(gate_count), lim);
        chk(overflow == (exp_n > MAX_GATES), {tag, " R7 overflow"}, int'(overflow),
            int'(exp_n > MAX_GATES));
        mism = 0; first_a = 0; first_e = 0;
        for (int k = 0; k < lim && k < got_n; k++) begin
            if (got_g[k] != exp_g[k]) begin
                if (mism == 0) begin first_a = got_g[k]; first_e = exp_g[k]; end
                mism++;
            end
        end
        chk(mism == 0, {tag, " R3 record contents"}, first_a, first_e);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MAX_CUBES; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(busy == 0 && done == 0 && gate_valid == 0, "R9 reset control", int'(busy), 0);
        chk(gate_count == 0 && overflow == 0, "R9 reset count", int'(gate_count), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: empty list
        run(0, 0, "empty");
        chk(got_n == 0, "R10 no records", got_n, 0);

        // R3: true literals x0,x2 feeding result 0 -> single gate ctrl 0101 target 4
        mem[0] = mk(3'b001, 4'b0101, 4'b0101);
        run(1, 0, "pos");
        chk(got_g[0] == enc(5, 4), "R3 positive cube gate", got_g[0], enc(5, 4));

        // R3/R6: shared negated literal x0 across two cubes -> one inverter, one restore
        mem[0] = mk(3'b001, 4'b0001, 4'b0000);
        mem[1] = mk(3'b010, 4'b0001, 4'b0000);
        run(2, 0, "share");
        chk(got_n == 4, "R3 shared inversion count", got_n, 4);
        chk(got_g[3] == enc(0, 0), "R6 restore inverter", got_g[3], enc(0, 0));

        // R4: empty mask cube with negated literal emits nothing
        mem[0] = mk(3'b000, 4'b1111, 4'b0000);
        run(1, 0, "nomask");
        chk(got_n == 0, "R4 skipped cube", got_n, 0);

        // R5: no literal present -> control-free gates on results 0 and 2
        mem[0] = mk(3'b101, 4'b0000, 4'b1010);
        run(1, 0, "const");
        chk(got_g[0] == enc(0, 4) && got_g[1] == enc(0, 6), "R5 const gates", got_g[1], enc(0, 6));

        // R7: alternating polarity, full masks -> exceeds capacity
        for (int i = 0; i < MAX_CUBES; i++)
            mem[i] = mk(3'b111, 4'b1111, (i % 2 == 0) ? 4'b0000 : 4'b1111);
        run(MAX_CUBES, 0, "ovf");
        chk(overflow == 1'b1, "R7 overflow set", int'(overflow), 1);

        // R8: start during a run is ignored; next start clears overflow
        for (int i = 0; i < 4; i++) mem[i] = mk(3'b011, 4'b0110, 4'b0010);
        run(4, 1, "restart");
        chk(overflow == 1'b0, "R8 overflow cleared", int'(overflow), 0);

        // R2/R3: random cube lists
        for (int t = 0; t < 30; t++) begin
            int cnt;
            cnt = 1 + int'($urandom % MAX_CUBES);
            for (int i = 0; i < MAX_CUBES; i++)
                mem[i] = mk(($urandom % 4 == 0) ? 0 : int'($urandom % 8),
                            int'($urandom % 16), int'($urandom % 16));
            run(cnt, 0, "rand");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Global watchdog
    initial begin
        repeat (150000) @(negedge clk);
        bad++;
        total++;
        $display("FAIL R8 global watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule